// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A host writes a byte with a one-cycle strobe into a holding register. When the serializer is free, the byte moves into the shift stage, and the block sends a low start bit, then 5 to 8 data bits, then an optional parity bit, then a high stop interval. The line idles high between frames.

Timing comes from an external enable that pulses once per sixteenth of a bit, so one bit lasts 16 such ticks. Frame shape is set by a group of line-control inputs: word length, parity enable, parity kind, parity stick, stop length and a break override. Two flags tell the host when it may write the next byte and when the line has gone fully quiet. Data can be written while a frame is still going out, so frames can follow each other with no idle gap.

Top module: `async_char_tx`

## Requirements
- R1: While reset is held and after it is released with no load, `line_out` is 1 and both `hold_empty` and `tx_empty` are 1.
- R2: The idle line is high. Each frame begins with a start bit that holds the line low for exactly 16 ticks.
- R3: Data bits are sent least significant bit first, 16 ticks each. The bit value appears on the line unchanged. The count is 5 + `cfg_len`, so code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: With `cfg_par_en` = 0 no parity bit is sent. With `cfg_par_en` = 1 one parity bit of 16 ticks follows the data. If `cfg_par_stick` = 0, then `cfg_par_even` = 0 makes the count of ones over data plus parity odd, and `cfg_par_even` = 1 makes that count even. If `cfg_par_stick` = 1, the parity bit is the inverse of `cfg_par_even`.
- R5: The stop interval is high for 16 ticks when `cfg_stop_long` = 0. When it is 1, the interval is 24 ticks for a 5-bit word and 32 ticks for any other length.
- R6: While `cfg_break` = 1, `line_out` is 0 whatever the transmitter is doing. The frame in progress keeps its timing underneath, so its end time does not change.
- R7: `hold_empty` goes to 0 on the cycle after an accepted load. It returns to 1 when the byte moves into the shift stage, which happens on a tick. `tx_empty` is 1 only when the holding register is empty and no frame is in progress, and it rises right after the tick that ends the last stop interval.
- R8: A load strobe while `hold_empty` = 0 is ignored. The held byte is not replaced and no extra frame is sent.
- R9: If a byte is waiting when a stop interval ends, the next start bit begins on that same tick, with no idle time between frames.
- R10: Word length, parity and stop settings are sampled when a frame starts. Changing them mid-frame does not affect that frame.
- R11: With the transmitter idle, a loaded byte waits for the next tick before its start bit begins. No start bit appears while ticks are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable, 16 per bit time |
| wr_strobe | input | 1 | Load strobe for `wr_byte` |
| wr_byte | input | DATA_W | Character to send |
| cfg_len | input | 2 | Word length code, data bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select, or inverse stick value |
| cfg_par_stick | input | 1 | Fixed-value parity |
| cfg_stop_long | input | 1 | Long stop interval select |
| cfg_break | input | 1 | Force line low |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and serializer both idle |
| line_out | output | 1 | Serial output, idle high |

## Verification
A fault in the tick counter or the bit index shows up on `line_out` within one bit time: a level sampled mid-slot comes out wrong, or the next frame's start bit arrives early or late. A fault in the stop length or the hand-off between frames shows only at the end of a frame. For that reason frames are sent back to back and the tick count from byte transfer to `tx_empty` is measured, so such a fault is caught within one frame. A fault in latching the line settings shows as a frame whose shape follows settings that were changed after it began.

// File: rtl/async_tx_pkg.sv
// Shared types for the asynchronous character transmitter.
// Assumes: data width of 8 with word lengths 5..8 encoded in two bits.
package async_tx_pkg;

    // Serializer phases, in frame order
    typedef enum logic [2:0] {
        TXS_IDLE  = 3'd0,
        TXS_START = 3'd1,
        TXS_DATA  = 3'd2,
        TXS_PAR   = 3'd3,
        TXS_STOP  = 3'd4
    } txs_e;

    // Width of the word length code
    localparam int LEN_W = 2;

endpackage

// File: rtl/atx_hold_reg.sv
// Holding register: captures one character on a load strobe while empty
// and hands it to the serializer when the serializer takes it.
// Assumes: take is only raised while the register is full.
module atx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] byte_q
);

    logic accept;

    // A strobe only counts when the register is empty
    assign accept = wr_strobe & ~full;

    // Occupancy flag and stored character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            byte_q <= '0;
        end else if (take) begin
            full   <= 1'b0;
        end else if (accept) begin
            full   <= 1'b1;
            byte_q <= wr_byte;
        end
    end

    // R8: a full register keeps its byte until the serializer takes it
    a_r8_full_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(byte_q)));

    // R7: the serializer takes only a byte that is present
    a_r7_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: rtl/atx_parity_gen.sv
// Parity bit generator: masks the character to the selected word length
// and forms odd, even or fixed-value parity.
// Assumes: DATA_W is 8, so the shortest word is DATA_W-3 bits.
module atx_parity_gen
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              [DATA_W-1:0] data,
    input  logic              [LEN_W-1:0]  len,
    input  logic                           even_sel,
    input  logic                           stick,
    output logic                           par_bit
);

    localparam int MIN_BITS = DATA_W - 3;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] used;
    logic              ones_odd;

    // Keep the always-sent low bits, and upper bits only up to the length
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < MIN_BITS) begin : g_fixed
            assign mask[i] = 1'b1;
        end else begin : g_var
            assign mask[i] = ({1'b0, len} >= 3'(i - MIN_BITS + 1));
        end
    end

    assign used     = data & mask;
    assign ones_odd = ^used;

    // Select parity kind: fixed value, even or odd
    always_comb begin
        if (stick) begin
            par_bit = ~even_sel;
        end else if (even_sel) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/atx_frame_seq.sv
// Frame sequencer: counts 16 ticks per bit, walks start, data, parity and
// stop phases, shifts data out LSB first and picks up the next byte at the
// tick that ends the stop interval.
// Assumes: tick_en is a one-cycle pulse; frame settings are latched at take.
module atx_frame_seq
    import async_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_byte,
    input  logic [LEN_W-1:0]  len,
    input  logic              par_en,
    input  logic              stop_long,
    input  logic              par_bit_in,
    output logic              take,
    output logic              line_raw,
    output logic              busy
);

    localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_BASE  = IDX_W'(MIN_BITS - 1);

    txs_e              state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  len_q;
    logic              par_en_q;
    logic              stop_long_q;
    logic              par_q;
    logic [CNT_W-1:0]  stop_last;
    logic [IDX_W-1:0]  idx_last;
    logic              bit_done;
    logic              stop_done;

    // Last tick index of the stop interval for the latched settings
    always_comb begin
        if (!stop_long_q) begin
            stop_last = BIT_LAST;
        end else if (len_q == '0) begin
            stop_last = HALF_LAST;
        end else begin
            stop_last = TWO_LAST;
        end
    end

    // Index of the last data bit and end-of-slot flags
    assign idx_last  = IDX_BASE + IDX_W'(len_q);
    assign bit_done  = (cnt == BIT_LAST);
    assign stop_done = (state == TXS_STOP) && (cnt == stop_last);

    // Take the waiting byte on a tick when idle or when the stop ends
    assign take = tick_en & hold_full & ((state == TXS_IDLE) | stop_done);

    // Phase, tick counter, bit index and shift stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= TXS_IDLE;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= '0;
            len_q       <= '0;
            par_en_q    <= 1'b0;
            stop_long_q <= 1'b0;
            par_q       <= 1'b0;
        end else if (take) begin
            state       <= TXS_START;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= hold_byte;
            len_q       <= len;
            par_en_q    <= par_en;
            stop_long_q <= stop_long;
            par_q       <= par_bit_in;
        end else if (tick_en) begin
            unique case (state)
                TXS_IDLE: begin
                    cnt <= '0;
                end
                TXS_START: begin
                    if (bit_done) begin
                        state <= TXS_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TXS_DATA: begin
                    if (bit_done) begin
                        cnt   <= '0;
                        shreg <= shreg >> 1;
                        if (idx == idx_last) begin
                            state <= par_en_q ? TXS_PAR : TXS_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TXS_PAR: begin
                    if (bit_done) begin
                        state <= TXS_STOP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TXS_STOP: begin
                    if (stop_done) begin
                        state <= TXS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= TXS_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Line level for the current phase
    always_comb begin
        unique case (state)
            TXS_IDLE:  line_raw = 1'b1;
            TXS_START: line_raw = 1'b0;
            TXS_DATA:  line_raw = shreg[0];
            TXS_PAR:   line_raw = par_q;
            TXS_STOP:  line_raw = 1'b1;
            default:   line_raw = 1'b1;
        endcase
    end

    assign busy = (state != TXS_IDLE);

    // R11: a frame only begins after a tick with a byte waiting
    a_r11_start_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXS_START && $past(state) != TXS_START) |-> ($past(tick_en) && $past(hold_full)));

    // R6: without a tick the frame timing does not move
    a_r6_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(state) && $stable(cnt)));

    // R3: the bit index stays within the latched word length
    a_r3_idx_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXS_DATA) |-> (idx <= idx_last));

endmodule

// File: rtl/async_char_tx.sv
// Configurable asynchronous character transmitter: holding register,
// parity generator and frame sequencer, with a break override on the line.
// Assumes: tick_en pulses 16 times per bit; settings are stable at frame start.
module async_char_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              cfg_stop_long,
    input  logic              cfg_break,
    output logic              hold_empty,
    output logic              tx_empty,
    output logic              line_out
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_byte;
    logic              take;
    logic              par_bit;
    logic              line_raw;
    logic              busy;

    atx_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_byte   (wr_byte),
        .take      (take),
        .full      (hold_full),
        .byte_q    (hold_byte)
    );

    atx_parity_gen #(
        .DATA_W (DATA_W)
    ) u_par (
        .data     (hold_byte),
        .len      (cfg_len),
        .even_sel (cfg_par_even),
        .stick    (cfg_par_stick),
        .par_bit  (par_bit)
    );

    atx_frame_seq #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .hold_full  (hold_full),
        .hold_byte  (hold_byte),
        .len        (cfg_len),
        .par_en     (cfg_par_en),
        .stop_long  (cfg_stop_long),
        .par_bit_in (par_bit),
        .take       (take),
        .line_raw   (line_raw),
        .busy       (busy)
    );

    // Status flags and break override on the line
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~busy;
    assign line_out   = line_raw & ~cfg_break;

    // R7: the holding register empties only as a frame starts
    a_r7_empty_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full) |-> busy);

    // R2: an idle sequencer leaves the line high unless a break is forced
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_break) |-> line_out);

endmodule

// File: tb/async_char_tx_bench.sv
`timescale 1ns/1ps
module async_char_tx_bench;

    typedef struct {
        logic [31:0] lv;
        int          n;
        int          nb;
        bit          par;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_byte = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       cfg_stop_long = 1'b0;
    logic       cfg_break = 1'b0;
    logic       hold_empty;
    logic       tx_empty;
    logic       line_out;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   tick_run = 1'b0;
    int   tick_ph = 0;
    logic tick_hit = 1'b0;
    bit   mon_on = 1'b1;
    bit   mon_active = 1'b0;
    int   frames_done = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    async_char_tx u_async_char_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .wr_strobe     (wr_strobe),
        .wr_byte       (wr_byte),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .cfg_stop_long (cfg_stop_long),
        .cfg_break     (cfg_break),
        .hold_empty    (hold_empty),
        .tx_empty      (tx_empty),
        .line_out      (line_out)
    );

    // Tick source: one pulse every 4 cycles while running
    always @(negedge clk) begin
        if (tick_run) begin
            tick_en = (tick_ph == 3);
            tick_ph = (tick_ph + 1) % 4;
        end else begin
            tick_en = 1'b0;
        end
    end

    always @(posedge clk) tick_hit <= tick_en;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string slot_tag(input exp_t e, input int h);
        if (h < 2) return "R2 start bit";
        if (h < 2 + 2 * e.nb) return "R3 data bit";
        if (e.par && h < 4 + 2 * e.nb) return "R4 parity bit";
        return "R5 stop interval";
    endfunction

    // Expected frame from the requirements, in half-bit slots
    function automatic exp_t build(input logic [7:0] d);
        exp_t e;
        logic p;
        int   ns;
        e.lv = '0;
        e.n = 2;
        e.nb = 5 + int'(cfg_len);
        e.par = cfg_par_en;
        for (int i = 0; i < e.nb; i++) begin
            e.lv[e.n] = d[i];
            e.lv[e.n + 1] = d[i];
            e.n += 2;
        end
        if (cfg_par_en) begin
            if (cfg_par_stick) begin
                p = ~cfg_par_even;
            end else begin
                p = 1'b0;
                for (int i = 0; i < e.nb; i++) p ^= d[i];
                if (!cfg_par_even) p = ~p;
            end
            e.lv[e.n] = p;
            e.lv[e.n + 1] = p;
            e.n += 2;
        end
        ns = !cfg_stop_long ? 2 : (e.nb == 5 ? 3 : 4);
        for (int i = 0; i < ns; i++) begin
            e.lv[e.n] = 1'b1;
            e.n++;
        end
        return e;
    endfunction

    // Monitor: finds start edges and samples the middle of each half slot
    logic prev_line = 1'b1;
    exp_t cur;
    int   mk = 0;
    int   mh = 0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (!mon_active) begin
                if (prev_line && !line_out) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R8/R11 unexpected frame start", 0, 1);
                    end else begin
                        cur = q.pop_front();
                        mon_active = 1'b1;
                        mk = 0;
                        mh = 0;
                    end
                end
            end else if (tick_hit) begin
                mk++;
                if (mk == 8 * mh + 4) begin
                    chk(line_out == cur.lv[mh], slot_tag(cur, mh), int'(line_out), int'(cur.lv[mh]));
                    mh++;
                    if (mh == cur.n) begin
                        mon_active = 1'b0;
                        frames_done++;
                    end
                end
            end
        end
        prev_line = line_out;
    end

    // Driver: waits for room, records the expected frame, strobes the byte
    task automatic send(input logic [7:0] d);
        while (!hold_empty) @(negedge clk);
        if (mon_on) q.push_back(build(d));
        wr_byte = d;
        wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        chk(hold_empty == 1'b0, "R7 hold_empty after load", int'(hold_empty), 0);
    endtask

    task automatic drain();
        while (!tx_empty || mon_active || !hold_empty) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // Ticks from the byte transfer until tx_empty rises
    task automatic count_to_empty(output int cnt);
        cnt = 0;
        while (1) begin
            @(negedge clk);
            if (tick_hit) cnt++;
            if (tx_empty) break;
        end
    endtask

    task automatic measure(input logic [7:0] d, input int exp_ticks, input string tag);
        int c;
        send(d);
        while (!hold_empty) @(negedge clk);
        chk(tx_empty == 1'b0, "R7 tx_empty low during frame", int'(tx_empty), 0);
        count_to_empty(c);
        chk(c == exp_ticks, tag, c, exp_ticks);
        drain();
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic ev,
                           input logic st, input logic sl);
        cfg_len = l;
        cfg_par_en = pe;
        cfg_par_even = ev;
        cfg_par_stick = st;
        cfg_stop_long = sl;
    endtask

    initial begin
        int c;
        int f0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(line_out == 1'b1, "R1 line high in reset", int'(line_out), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_out == 1'b1, "R1 line high after reset", int'(line_out), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
        tick_run = 1'b1;
        repeat (20) @(negedge clk);
        chk(line_out == 1'b1, "R2 idle line stays high", int'(line_out), 1);

        // R2 R3 R5 R7: 8 data bits, no parity, short stop
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        measure(8'hA5, 160, "R5 R7 8N1 frame length");

        // R3 R4: word lengths and parity kinds
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hFB); drain();
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h2D); drain();
        set_cfg(2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h55); drain();
        set_cfg(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        send(8'h0F); drain();
        set_cfg(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        send(8'hF1); drain();
        set_cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h01); drain();

        // R5: long stop intervals
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        measure(8'h13, 120, "R5 5-bit long stop length");
        set_cfg(2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
        measure(8'h6E, 176, "R5 7-bit parity long stop length");

        // R9: back-to-back frames without a gap
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h3C);
        while (!hold_empty) @(negedge clk);
        send(8'hC3);
        count_to_empty(c);
        chk(c == 320, "R9 two frames back to back", c, 320);
        drain();
        set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        send(8'h0A); send(8'h15); send(8'h1F);
        drain();

        // R8 R11: load while full is dropped; no start without ticks
        tick_run = 1'b0;
        repeat (3) @(negedge clk);
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        f0 = frames_done;
        send(8'h3C);
        wr_byte = 8'hFF;
        wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        repeat (10) @(negedge clk);
        chk(hold_empty == 1'b0, "R8 held byte still waiting", int'(hold_empty), 0);
        chk(line_out == 1'b1, "R11 no start bit without ticks", int'(line_out), 1);
        tick_run = 1'b1;
        drain();
        repeat (40) @(negedge clk);
        chk(frames_done - f0 == 1, "R8 only one frame sent", frames_done - f0, 1);

        // R10: settings changed mid-frame do not affect it
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h81);
        while (!hold_empty) @(negedge clk);
        set_cfg(2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        count_to_empty(c);
        chk(c == 160, "R10 frame keeps latched settings", c, 160);
        drain();

        // R6: break while idle and during a frame
        mon_on = 1'b0;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_break = 1'b1;
        repeat (12) @(negedge clk);
        chk(line_out == 1'b0, "R6 break forces line low at idle", int'(line_out), 0);
        chk(tx_empty == 1'b1, "R6 break leaves transmitter idle", int'(tx_empty), 1);
        cfg_break = 1'b0;
        @(negedge clk);
        chk(line_out == 1'b1, "R6 line high after break release", int'(line_out), 1);
        send(8'h00);
        while (!hold_empty) @(negedge clk);
        c = 0;
        while (1) begin
            @(negedge clk);
            if (tick_hit) begin
                c++;
                if (c == 20) cfg_break = 1'b1;
                if (c == 40) chk(line_out == 1'b0, "R6 break low during frame", int'(line_out), 0);
                if (c == 150) chk(line_out == 1'b0, "R6 break low during stop", int'(line_out), 0);
                if (c == 152) cfg_break = 1'b0;
            end
            if (tx_empty) break;
        end
        chk(c == 160, "R6 frame timing kept under break", c, 160);
        repeat (4) @(negedge clk);
        chk(line_out == 1'b1, "R6 idle high after break frame", int'(line_out), 1);
        mon_on = 1'b1;

        chk(q.size() == 0, "R3 all expected frames seen", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule